// File: doc/BRIEF.md
# Channel Scan Sequencer with Range Pointer

This block picks the analog multiplexer channel for a data acquisition front end. The host writes one scan byte. Its upper nibble names the last channel of a scan and its lower nibble names the first. Each conversion trigger moves the selection one step forward. After the last channel the selection returns to the first, so a group of inputs is sampled in turn with no host action between conversions. A write to the scan byte restarts the sequence at its first channel.

The lower nibble of the scan byte also points into a sixteen-entry table of 4-bit gain codes. The host loads this table through a separate port. The selected channel reads its own gain code from the table. The host can choose single-ended mode, which gives sixteen channels, or differential mode, which gives eight. In differential mode the upper bit of every channel number is cleared.

A two-state tag machine marks each conversion result with the channel it came from. In TAG_IDLE no tag is shown. The machine moves from TAG_IDLE to TAG_OUT on a trigger. It stays in TAG_OUT while triggers keep arriving on consecutive cycles, and it goes back to TAG_IDLE on the first cycle with no trigger. The tag channel is captured on the same edge that advances the pointer, so it holds the channel that was sampled and not the one that follows.

Top module: `scan_seq`

## Requirements
- R1: After reset, the scan byte read-back, the current channel, the tag valid flag and every gain code in the table are all zero.
- R2: A scan write stores the byte: bits 7:4 hold the stop channel and bits 3:0 hold the start channel. The byte can be read back on `scan_rdata` after the next clock edge. On that same edge the current channel is forced to the start channel.
- R3: A trigger advances the current channel by one on the next edge. When the current channel equals the stop channel, it goes back to the start channel instead. For example, start 3 and stop 7 gives 3,4,5,6,7,3,4.
- R4: When start equals stop, the current channel stays at that value across any number of triggers.
- R5: When start is greater than stop, the channel counts up through 15, wraps to 0, and continues to stop before it returns to start.
- R6: A gain write stores `range_wdata` into the table entry addressed by the stored start nibble. `cur_range` always shows the table entry of the current channel.
- R7: In differential mode (`diff_mode` = 1), a scan write clears bit 3 and bit 7 of the stored byte. Channel advance then counts modulo 8, so the step after 7 is 0.
- R8: `next_chan` shows the channel that the next trigger will select.
- R9: One edge after a trigger, `tag_valid` is 1 and `tag_chan` holds the channel that was current when the trigger arrived. `tag_valid` is 0 after any edge without a trigger.
- R10: When a scan write and a trigger arrive in the same cycle, the write decides the next channel, which is the new start. The tag still records the channel that was current before the edge.
- R11: With no trigger and no scan write, the current channel holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| diff_mode | input | 1 | 1 selects eight differential channels, 0 selects sixteen single-ended channels |
| scan_wr | input | 1 | Strobe that writes the scan byte |
| scan_wdata | input | 8 | Scan byte: stop channel in bits 7:4, start channel in bits 3:0 |
| range_wr | input | 1 | Strobe that writes a gain code at the start-channel entry |
| range_wdata | input | 4 | Gain code to store |
| trig | input | 1 | Conversion trigger strobe |
| scan_rdata | output | 8 | Read-back of the stored scan byte |
| cur_chan | output | 4 | Channel currently driven to the multiplexer |
| cur_range | output | 4 | Gain code of the current channel |
| next_chan | output | 4 | Channel that the next trigger will select |
| tag_valid | output | 1 | A conversion was triggered on the previous edge |
| tag_chan | output | 4 | Channel that the last conversion was taken from |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a scan write and a trigger. The stimulus table asserts both strobes together while a scan is running, and the bench then expects the current channel to be the new start and the tag to be the channel from before the edge. The second pair is a gain write and a trigger. The bench issues both together, then rewinds to the written entry and expects the stored code there, unaffected by the pointer moving on the same edge.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [0:0] {
        TAG_IDLE = 1'b0,
        TAG_OUT  = 1'b1
    } tag_state_e;

    // Clear the upper bit of a channel number (eight-channel mode)
    function automatic logic [3:0] half_mask4(input logic [3:0] ch);
        return {1'b0, ch[2:0]};
    endfunction

endpackage

// File: rtl/scan_limits.sv
module scan_limits #(
    parameter int CH_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              diff_mode,
    input  logic              wr,
    input  logic [2*CH_W-1:0] wdata,
    output logic [CH_W-1:0]   start_ch,
    output logic [CH_W-1:0]   stop_ch,
    output logic [CH_W-1:0]   load_ch,
    output logic [2*CH_W-1:0] rdata
);
    localparam int BYTE_W = 2 * CH_W;
    localparam logic [CH_W-1:0] TOP_CLR = {1'b0, {(CH_W-1){1'b1}}};

    logic [BYTE_W-1:0] lim_q;
    logic [BYTE_W-1:0] lim_in;

    always_comb begin
        if (diff_mode) begin
            lim_in = {wdata[BYTE_W-1:CH_W] & TOP_CLR, wdata[CH_W-1:0] & TOP_CLR};
        end else begin
            lim_in = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
        end else if (wr) begin
            lim_q <= lim_in;
        end
    end

    assign start_ch = lim_q[CH_W-1:0];
    assign stop_ch  = lim_q[BYTE_W-1:CH_W];
    assign load_ch  = lim_in[CH_W-1:0];
    assign rdata    = lim_q;

endmodule

// File: rtl/scan_pointer.sv
module scan_pointer
    import scan_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            diff_mode,
    input  logic            load,
    input  logic [CH_W-1:0] load_ch,
    input  logic [CH_W-1:0] start_ch,
    input  logic [CH_W-1:0] stop_ch,
    input  logic            trig,
    output logic [CH_W-1:0] cur_ch,
    output logic [CH_W-1:0] succ_ch,
    output logic            tag_valid,
    output logic [CH_W-1:0] tag_ch
);
    localparam logic [CH_W-1:0] HALF = {1'b0, {(CH_W-1){1'b1}}};
    localparam logic [CH_W-1:0] ONE  = CH_W'(1);

    tag_state_e      state_q, state_d;
    logic [CH_W-1:0] cur_q;
    logic [CH_W-1:0] inc_ch;
    logic [CH_W-1:0] tag_q;

    // Successor channel: wrap at stop, count modulo the channel space
    always_comb begin
        inc_ch = cur_q + ONE;
        if (diff_mode) begin
            inc_ch = inc_ch & HALF;
        end
        succ_ch = (cur_q == stop_ch) ? start_ch : inc_ch;
    end

    // Channel pointer: a scan write takes priority over a trigger
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= load_ch;
        end else if (trig) begin
            cur_q <= succ_ch;
        end
    end

    // Tag capture of the channel being converted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (trig) begin
            tag_q <= cur_q;
        end
    end

    // Tag state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Tag state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TAG_IDLE: state_d = trig ? TAG_OUT : TAG_IDLE;
            TAG_OUT:  state_d = trig ? TAG_OUT : TAG_IDLE;
            default:  state_d = TAG_IDLE;
        endcase
    end

    // Tag state machine: outputs
    always_comb begin
        tag_valid = 1'b0;
        unique case (state_q)
            TAG_IDLE: tag_valid = 1'b0;
            TAG_OUT:  tag_valid = 1'b1;
            default:  tag_valid = 1'b0;
        endcase
    end

    assign cur_ch = cur_q;
    assign tag_ch = tag_q;

endmodule

// File: rtl/range_mem.sv
module range_mem #(
    parameter int CH_W    = 4,
    parameter int RANGE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [CH_W-1:0]    waddr,
    input  logic [RANGE_W-1:0] wdata,
    input  logic [CH_W-1:0]    raddr,
    output logic [RANGE_W-1:0] rdata
);
    localparam int DEPTH = 1 << CH_W;

    logic [RANGE_W-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry[i] <= '0;
            end else if (wr && (waddr == CH_W'(i))) begin
                entry[i] <= wdata;
            end
        end
    end

    assign rdata = entry[raddr];

endmodule

// File: rtl/scan_seq.sv
module scan_seq #(
    parameter int CH_W    = 4,
    parameter int RANGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              diff_mode,
    input  logic              scan_wr,
    input  logic [2*CH_W-1:0] scan_wdata,
    input  logic              range_wr,
    input  logic [RANGE_W-1:0] range_wdata,
    input  logic              trig,
    output logic [2*CH_W-1:0] scan_rdata,
    output logic [CH_W-1:0]   cur_chan,
    output logic [RANGE_W-1:0] cur_range,
    output logic [CH_W-1:0]   next_chan,
    output logic              tag_valid,
    output logic [CH_W-1:0]   tag_chan
);
    logic [CH_W-1:0] start_ch;
    logic [CH_W-1:0] stop_ch;
    logic [CH_W-1:0] load_ch;

    scan_limits #(.CH_W(CH_W)) u_limits (
        .clk       (clk),
        .rst_n     (rst_n),
        .diff_mode (diff_mode),
        .wr        (scan_wr),
        .wdata     (scan_wdata),
        .start_ch  (start_ch),
        .stop_ch   (stop_ch),
        .load_ch   (load_ch),
        .rdata     (scan_rdata)
    );

    scan_pointer #(.CH_W(CH_W)) u_pointer (
        .clk       (clk),
        .rst_n     (rst_n),
        .diff_mode (diff_mode),
        .load      (scan_wr),
        .load_ch   (load_ch),
        .start_ch  (start_ch),
        .stop_ch   (stop_ch),
        .trig      (trig),
        .cur_ch    (cur_chan),
        .succ_ch   (next_chan),
        .tag_valid (tag_valid),
        .tag_ch    (tag_chan)
    );

    range_mem #(.CH_W(CH_W), .RANGE_W(RANGE_W)) u_ranges (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (range_wr),
        .waddr (start_ch),
        .wdata (range_wdata),
        .raddr (cur_chan),
        .rdata (cur_range)
    );

endmodule

// File: rtl/scan_seq_chk.sv
module scan_seq_chk #(
    parameter int CH_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_wr,
    input logic              trig,
    input logic [2*CH_W-1:0] scan_rdata,
    input logic [CH_W-1:0]   cur_chan,
    input logic [CH_W-1:0]   next_chan,
    input logic              tag_valid,
    input logic [CH_W-1:0]   tag_chan
);
    // R2: a scan write places the pointer at the stored start nibble
    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scan_wr |=> (cur_chan == scan_rdata[CH_W-1:0]));

    // R3: at the stop channel a trigger returns to the start channel
    p_wrap_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !scan_wr && (cur_chan == scan_rdata[2*CH_W-1:CH_W]))
        |=> (cur_chan == scan_rdata[CH_W-1:0]));

    // R8: the reported successor is the channel a trigger actually selects
    p_next_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !scan_wr) |=> (cur_chan == $past(next_chan)));

    // R9: a trigger tags the channel that was current at the trigger
    p_tag_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (tag_valid && (tag_chan == $past(cur_chan))));

    // R9: no trigger, no valid tag
    p_tag_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> !tag_valid);

    // R11: idle cycles leave the pointer alone
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !scan_wr) |=> $stable(cur_chan));

endmodule

bind scan_seq scan_seq_chk #(.CH_W(CH_W)) u_scan_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_wr    (scan_wr),
    .trig       (trig),
    .scan_rdata (scan_rdata),
    .cur_chan   (cur_chan),
    .next_chan  (next_chan),
    .tag_valid  (tag_valid),
    .tag_chan   (tag_chan)
);

// File: tb/scan_seq_test.sv
module scan_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       diff_mode = 1'b0;
    logic       scan_wr = 1'b0;
    logic [7:0] scan_wdata = 8'h00;
    logic       range_wr = 1'b0;
    logic [3:0] range_wdata = 4'h0;
    logic       trig = 1'b0;
    logic [7:0] scan_rdata;
    logic [3:0] cur_chan;
    logic [3:0] cur_range;
    logic [3:0] next_chan;
    logic       tag_valid;
    logic [3:0] tag_chan;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_start = 4'd0;
    logic [3:0] exp_stop  = 4'd0;

    always #10 clk = ~clk;

    scan_seq uut (
        .clk(clk), .rst_n(rst_n), .diff_mode(diff_mode),
        .scan_wr(scan_wr), .scan_wdata(scan_wdata),
        .range_wr(range_wr), .range_wdata(range_wdata), .trig(trig),
        .scan_rdata(scan_rdata), .cur_chan(cur_chan), .cur_range(cur_range),
        .next_chan(next_chan), .tag_valid(tag_valid), .tag_chan(tag_chan)
    );

    // {scan_wr, scan_wdata, trig, exp_cur, exp_tag_valid, exp_tag}
    localparam int NV = 17;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 8'h73, 1'b0, 4'd3,  1'b0, 4'd0},
        {1'b0, 8'h00, 1'b1, 4'd4,  1'b1, 4'd3},
        {1'b0, 8'h00, 1'b1, 4'd5,  1'b1, 4'd4},
        {1'b0, 8'h00, 1'b1, 4'd6,  1'b1, 4'd5},
        {1'b0, 8'h00, 1'b1, 4'd7,  1'b1, 4'd6},
        {1'b0, 8'h00, 1'b1, 4'd3,  1'b1, 4'd7},
        {1'b0, 8'h00, 1'b1, 4'd4,  1'b1, 4'd3},
        {1'b1, 8'h2D, 1'b1, 4'd13, 1'b1, 4'd4},
        {1'b0, 8'h00, 1'b1, 4'd14, 1'b1, 4'd13},
        {1'b0, 8'h00, 1'b1, 4'd15, 1'b1, 4'd14},
        {1'b0, 8'h00, 1'b1, 4'd0,  1'b1, 4'd15},
        {1'b0, 8'h00, 1'b1, 4'd1,  1'b1, 4'd0},
        {1'b0, 8'h00, 1'b1, 4'd2,  1'b1, 4'd1},
        {1'b0, 8'h00, 1'b1, 4'd13, 1'b1, 4'd2},
        {1'b1, 8'h55, 1'b0, 4'd5,  1'b0, 4'd2},
        {1'b0, 8'h00, 1'b1, 4'd5,  1'b1, 4'd5},
        {1'b0, 8'h00, 1'b0, 4'd5,  1'b0, 4'd5}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_next(input logic [3:0] c, input logic dm);
        logic [3:0] n;
        n = c + 4'd1;
        if (dm) n[3] = 1'b0;
        return (c == exp_stop) ? exp_start : n;
    endfunction

    task automatic step(input logic w, input logic [7:0] d, input logic t);
        scan_wr = w; scan_wdata = d; trig = t;
        if (w) begin
            exp_start = diff_mode ? {1'b0, d[2:0]} : d[3:0];
            exp_stop  = diff_mode ? {1'b0, d[6:4]} : d[7:4];
        end
        @(negedge clk);
        scan_wr = 1'b0; trig = 1'b0;
    endtask

    function automatic string vec_req(input int i);
        if (i == 0) return "R2";
        if (i == 7) return "R10";
        if (i == 16) return "R11";
        if (i >= 14) return "R4";
        if (i >= 8) return "R5";
        return "R3";
    endfunction

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1 rdata", scan_rdata, 8'h00);
        check("R1 cur", {4'h0, cur_chan}, 8'h00);
        check("R1 tag_valid", {7'h0, tag_valid}, 8'h00);
        check("R1 range", {4'h0, cur_range}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // Stimulus table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][18], VEC[i][17:10], VEC[i][9]);
            check({vec_req(i), " cur"}, {4'h0, cur_chan}, {4'h0, VEC[i][8:5]});
            check("R9 tag_valid", {7'h0, tag_valid}, {7'h0, VEC[i][4]});
            check("R9 tag_chan", {4'h0, tag_chan}, {4'h0, VEC[i][3:0]});
            check("R8 next", {4'h0, next_chan}, {4'h0, model_next(VEC[i][8:5], 1'b0)});
        end
        check("R2 rdata", scan_rdata, 8'h55);

        // R6: load every gain code through the start nibble
        for (int k = 0; k < 16; k++) begin
            step(1'b1, {4'hF, 4'(k)}, 1'b0);
            range_wr = 1'b1; range_wdata = 4'(k) ^ 4'h9;
            @(negedge clk);
            range_wr = 1'b0;
        end
        step(1'b1, 8'hF0, 1'b0);
        check("R2 rdata", scan_rdata, 8'hF0);
        for (int k = 0; k < 16; k++) begin
            check("R6 range", {4'h0, cur_range}, {4'h0, 4'(k) ^ 4'h9});
            check("R3 cur", {4'h0, cur_chan}, 8'(k));
            step(1'b0, 8'h00, 1'b1);
        end
        check("R3 wrap", {4'h0, cur_chan}, 8'h00);

        // R6: gain write and trigger together
        range_wr = 1'b1; range_wdata = 4'h3;
        step(1'b0, 8'h00, 1'b1);
        range_wr = 1'b0;
        check("R6 cur moved", {4'h0, cur_chan}, 8'h01);
        step(1'b1, 8'hF0, 1'b0);
        check("R6 same-cycle write", {4'h0, cur_range}, 8'h03);

        // R7: differential mode masks and wraps modulo 8
        diff_mode = 1'b1;
        step(1'b1, 8'hFD, 1'b0);
        check("R7 rdata", scan_rdata, 8'h75);
        check("R7 cur", {4'h0, cur_chan}, 8'h05);
        step(1'b0, 8'h00, 1'b1);
        check("R7 cur", {4'h0, cur_chan}, 8'h06);
        step(1'b0, 8'h00, 1'b1);
        check("R7 cur", {4'h0, cur_chan}, 8'h07);
        step(1'b0, 8'h00, 1'b1);
        check("R7 cur", {4'h0, cur_chan}, 8'h05);
        step(1'b1, 8'h16, 1'b0);
        check("R7 cur", {4'h0, cur_chan}, 8'h06);
        check("R8 next", {4'h0, next_chan}, 8'h07);
        step(1'b0, 8'h00, 1'b1);
        check("R8 next", {4'h0, next_chan}, {4'h0, model_next(4'd7, 1'b1)});
        step(1'b0, 8'h00, 1'b1);
        check("R7 wrap", {4'h0, cur_chan}, 8'h00);
        step(1'b0, 8'h00, 1'b1);
        check("R7 cur", {4'h0, cur_chan}, 8'h01);
        step(1'b0, 8'h00, 1'b1);
        check("R7 back to start", {4'h0, cur_chan}, 8'h06);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule